// File: doc/BRIEF.md
# SIMD Floor-to-Integral Unit

This block takes one packed vector of floating-point lanes and rounds every lane toward negative infinity to an integral value. The result keeps the lane's floating-point format and width. A size code picks 16-bit half-precision or 32-bit single-precision lanes. A quad flag picks 128-bit operation (two doublewords) or 64-bit operation (the low doubleword only). The destination and source register indices travel with each operation only so that the block can check their alignment. The block raises an undefined-operation flag for illegal sizes and misaligned quad indices. It raises an invalid-operation flag when a lane holds a signalling NaN. It never reports inexact.

Operations enter and leave on valid/ready streams through a single register stage. The input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays on the output, unchanged, until `out_ready` takes it. The producer must hold every input field steady while `in_valid` is high and `in_ready` is low. `half_en` is a plain control level, sampled together with the operation.

Top module: `simd_floor_unit`

## Requirements
- R1: Each active lane that holds a finite normal number is replaced by the largest integral value not greater than it, in the same format. Positive fractional parts are discarded.
- R2: Size code 2'b01 treats each 64-bit doubleword as four 16-bit lanes (1 sign, 5 exponent, 10 mantissa bits, lane 0 in bits 15:0). Size code 2'b10 treats it as two 32-bit lanes (1 sign, 8 exponent, 23 mantissa bits, lane 0 in bits 31:0).
- R3: Size codes 2'b00 and 2'b11 raise `out_undef`, and so does 2'b01 while `half_en` is low. An undefined result has `out_data` all zero and `out_invalid` low.
- R4: With `in_quad` high, an odd `in_dst_idx` or an odd `in_src_idx` (bit 0 set) raises `out_undef`. Even indices are legal.
- R5: With `in_quad` low, only bits 63:0 are processed, and `out_data[127:64]` is zero.
- R6: A zero lane, +0 or -0, yields the same signed zero.
- R7: An infinite lane yields an infinity with the same sign.
- R8: Any NaN lane yields the default quiet NaN: sign 0, exponent all ones, mantissa MSB set, all other bits 0. A NaN whose mantissa MSB is 0 (a signalling NaN) in an active lane also raises `out_invalid`.
- R9: A negative value with a nonzero fraction moves to the next more negative integer. A negative magnitude below 1 gives -1.0, and a positive magnitude below 1 gives +0.0.
- R10: A finite value of magnitude at least 2^10 (half) or 2^23 (single) passes through bit-exact.
- R11: A denormal lane is flushed to a zero of its own sign.
- R12: A result appears on the output the cycle after it is accepted. While `out_valid` is high and `out_ready` is low, the output is held stable. `in_ready` equals `!out_valid || out_ready`, and it is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | Half-precision lanes permitted |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_size | input | 2 | Lane size code |
| in_quad | input | 1 | 128-bit operation when high |
| in_dst_idx | input | 5 | Destination doubleword index (alignment check only) |
| in_src_idx | input | 5 | Source doubleword index (alignment check only) |
| in_data | input | 128 | Packed operand lanes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 128 | Packed rounded lanes |
| out_undef | output | 1 | Undefined-operation flag |
| out_invalid | output | 1 | Invalid-operation flag (signalling NaN seen) |

## Verification
The hardest case to reach from the ports is the carry out of the truncated mantissa. A negative value just below an integer boundary must round up in magnitude. This carry ripples through every mantissa bit and bumps the exponent. The stimulus places -1.5 in a half lane and the bit pattern just below -1.0 in a single lane to force this carry. A second hard case is a result held under back-pressure. The consumer withholds `out_ready` on a recurring pattern and also through one long stall, so results must stay stable and stay in order. A reference built from real-number floor arithmetic then checks every returned vector.

// File: rtl/floor_pkg.sv
package floor_pkg;
  typedef enum logic [1:0] {
    LSZ_RSV_LO = 2'b00,
    LSZ_HALF   = 2'b01,
    LSZ_SINGLE = 2'b10,
    LSZ_RSV_HI = 2'b11
  } lane_size_e;

  localparam int HALF_EXP_W = 5;
  localparam int HALF_MAN_W = 10;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_MAN_W  = 23;
  localparam int DWORD_W    = 64;
endpackage

// File: rtl/floor_lane.sv
module floor_lane #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op,
  output logic [EXP_W+MAN_W:0] res,
  output logic                 snan
);
  localparam int W    = 1 + EXP_W + MAN_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] LIM_E  = EXP_W'(BIAS + MAN_W);

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic [EXP_W-1:0] fb;
  logic [MAN_W:0]   one_at;
  logic [MAN_W:0]   mask_w;
  logic [MAN_W-1:0] frac;
  logic [MAN_W-1:0] trunc;
  logic [MAN_W+1:0] sig;

  assign sgn = op[W-1];
  assign ex  = op[W-2:MAN_W];
  assign mn  = op[MAN_W-1:0];

  always_comb begin
    res    = op;
    snan   = 1'b0;
    fb     = LIM_E - ex;
    one_at = (MAN_W+1)'(1) << fb;
    mask_w = one_at - (MAN_W+1)'(1);
    frac   = mn & mask_w[MAN_W-1:0];
    trunc  = mn & ~mask_w[MAN_W-1:0];
    sig    = {2'b01, trunc} + ((sgn && (frac != '0)) ? {1'b0, one_at} : '0);
    if (ex == '1) begin
      if (mn != '0) begin
        res  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
        snan = ~mn[MAN_W-1];
      end
    end else if (ex == '0) begin
      res = {sgn, {(W-1){1'b0}}};
    end else if (ex < BIAS_E) begin
      res = sgn ? {1'b1, BIAS_E, {MAN_W{1'b0}}} : '0;
    end else if (ex >= LIM_E) begin
      res = op;
    end else if (sig[MAN_W+1]) begin
      res = {sgn, ex + EXP_W'(1), {MAN_W{1'b0}}};
    end else begin
      res = {sgn, ex, sig[MAN_W-1:0]};
    end
  end

  always_comb begin
    if (!(ex == '1 && mn != '0)) begin
      // R1
      sign_keep_chk: assert (res[W-1] == sgn);
    end
    if (ex == '0 && mn == '0) begin
      // R6
      zero_keep_chk: assert (res == op);
    end
    if (snan) begin
      // R8
      nan_quiet_chk: assert (res[MAN_W-1] && res[W-2:MAN_W] == '1);
    end
  end
endmodule

// File: rtl/floor_lane_array.sv
module floor_lane_array #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]    vec,
  output logic [VEC_W-1:0]    half_res,
  output logic [VEC_W-1:0]    sgl_res,
  output logic [VEC_W/16-1:0] half_snan,
  output logic [VEC_W/32-1:0] sgl_snan
);
  import floor_pkg::*;
  localparam int HALF_W = 1 + HALF_EXP_W + HALF_MAN_W;
  localparam int SGL_W  = 1 + SGL_EXP_W + SGL_MAN_W;
  localparam int HALF_N = VEC_W / HALF_W;
  localparam int SGL_N  = VEC_W / SGL_W;

  for (genvar h = 0; h < HALF_N; h++) begin : g_half
    floor_lane #(.EXP_W(HALF_EXP_W), .MAN_W(HALF_MAN_W)) u_lane (
      .op  (vec[h*HALF_W +: HALF_W]),
      .res (half_res[h*HALF_W +: HALF_W]),
      .snan(half_snan[h])
    );
  end

  for (genvar s = 0; s < SGL_N; s++) begin : g_sgl
    floor_lane #(.EXP_W(SGL_EXP_W), .MAN_W(SGL_MAN_W)) u_lane (
      .op  (vec[s*SGL_W +: SGL_W]),
      .res (sgl_res[s*SGL_W +: SGL_W]),
      .snan(sgl_snan[s])
    );
  end
endmodule

// File: rtl/floor_decode_check.sv
module floor_decode_check #(
  parameter int IDX_W = 5
) (
  input  logic [1:0]       size,
  input  logic             quad,
  input  logic             half_en,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  output logic             is_half,
  output logic             undef
);
  import floor_pkg::*;
  lane_size_e sz;
  logic bad_size, bad_align;

  assign sz = lane_size_e'(size);

  always_comb begin
    is_half  = (sz == LSZ_HALF);
    unique case (sz)
      LSZ_HALF:   bad_size = ~half_en;
      LSZ_SINGLE: bad_size = 1'b0;
      default:    bad_size = 1'b1;
    endcase
    bad_align = quad & (dst_idx[0] | src_idx[0]);
    undef     = bad_size | bad_align;
  end

  always_comb begin
    if (quad && src_idx[0]) begin
      // R4
      odd_src_chk: assert (undef);
    end
  end
endmodule

// File: rtl/simd_floor_unit.sv
module simd_floor_unit #(
  parameter int VEC_W = 128,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_size,
  input  logic             in_quad,
  input  logic [IDX_W-1:0] in_dst_idx,
  input  logic [IDX_W-1:0] in_src_idx,
  input  logic [VEC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic             out_undef,
  output logic             out_invalid
);
  import floor_pkg::*;
  localparam int HALF_N  = VEC_W / 16;
  localparam int SGL_N   = VEC_W / 32;
  localparam int LO_W    = VEC_W / 2;

  logic [VEC_W-1:0]  half_res, sgl_res, sel_res, keep_mask, nxt_data;
  logic [HALF_N-1:0] half_snan, half_act;
  logic [SGL_N-1:0]  sgl_snan, sgl_act;
  logic              is_half, undef, nxt_inv, accept;

  floor_decode_check #(.IDX_W(IDX_W)) u_chk (
    .size   (in_size),
    .quad   (in_quad),
    .half_en(half_en),
    .dst_idx(in_dst_idx),
    .src_idx(in_src_idx),
    .is_half(is_half),
    .undef  (undef)
  );

  floor_lane_array #(.VEC_W(VEC_W)) u_lanes (
    .vec      (in_data),
    .half_res (half_res),
    .sgl_res  (sgl_res),
    .half_snan(half_snan),
    .sgl_snan (sgl_snan)
  );

  always_comb begin
    keep_mask = in_quad ? '1 : {{(VEC_W-LO_W){1'b0}}, {LO_W{1'b1}}};
    half_act  = in_quad ? '1 : {{(HALF_N/2){1'b0}}, {(HALF_N/2){1'b1}}};
    sgl_act   = in_quad ? '1 : {{(SGL_N/2){1'b0}}, {(SGL_N/2){1'b1}}};
    sel_res   = is_half ? half_res : sgl_res;
    nxt_data  = undef ? '0 : (sel_res & keep_mask);
    nxt_inv   = ~undef & (is_half ? |(half_snan & half_act) : |(sgl_snan & sgl_act));
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_undef   <= 1'b0;
      out_invalid <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_data    <= nxt_data;
      out_undef   <= undef;
      out_invalid <= nxt_inv;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_undef) && $stable(out_invalid));

  // R12
  drop_only_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  // R3
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_data == '0 && !out_invalid);
endmodule

// File: tb/tb_simd_floor_unit.sv
`timescale 1ns/1ps
module tb_simd_floor_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         half_en = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_size = 2'b10;
  logic         in_quad = 1'b0;
  logic [4:0]   in_dst_idx = '0;
  logic [4:0]   in_src_idx = '0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;
  logic         out_undef;
  logic         out_invalid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int sent   = 0;
  int got    = 0;
  logic [129:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  simd_floor_unit dut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_size(in_size),
    .in_quad(in_quad), .in_dst_idx(in_dst_idx), .in_src_idx(in_src_idx),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_undef(out_undef), .out_invalid(out_invalid)
  );

  function automatic real pow2(int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  // reference floor of one lane with E exponent and M mantissa bits
  function automatic logic [31:0] ref_lane(int E, int M, logic [31:0] b, output logic sn);
    int w = 1 + E + M;
    int all1 = (1 << E) - 1;
    int bias = (1 << (E - 1)) - 1;
    int s  = int'(b[w-1]);
    int ex = int'((b >> M) & 32'(all1));
    int mn = int'(b & 32'((1 << M) - 1));
    real v, r, a;
    int e2;
    longint man;
    sn = 1'b0;
    if (ex == all1) begin
      if (mn != 0) begin
        sn = ((mn >> (M - 1)) & 1) == 0;
        return 32'((all1 << M) | (1 << (M - 1)));
      end
      return b;
    end
    if (ex == 0) return 32'(s) << (w - 1);
    v = (1.0 + real'(mn) / pow2(M)) * pow2(ex - bias);
    if (s != 0) v = -v;
    r = $floor(v);
    if (r == 0.0) return 32'd0;
    a = (r < 0.0) ? -r : r;
    e2 = 0;
    while (a >= 2.0) begin a = a / 2.0; e2++; end
    man = longint'((a - 1.0) * pow2(M));
    return (32'(r < 0.0) << (w - 1)) | (32'(e2 + bias) << M) | 32'(man);
  endfunction

  task automatic send(input logic [1:0] sz, input logic q, input logic he,
                      input logic [4:0] di, input logic [4:0] si,
                      input logic [127:0] d, input string tag);
    logic [127:0] ed = '0;
    logic eu, ei = 1'b0, sn;
    int lw, E, M, nd;
    eu = (sz == 2'b00) || (sz == 2'b11) || (sz == 2'b01 && !he) || (q && (di[0] || si[0]));
    if (!eu) begin
      if (sz == 2'b01) begin lw = 16; E = 5; M = 10; end
      else begin lw = 32; E = 8; M = 23; end
      nd = q ? 2 : 1;
      for (int k = 0; k < nd * 64 / lw; k++) begin
        logic [31:0] rv = ref_lane(E, M, 32'(d[k*lw +: 32] & ((64'd1 << lw) - 1)), sn);
        for (int t = 0; t < lw; t++) ed[k*lw + t] = rv[t];
        ei = ei | sn;
      end
    end
    @(negedge clk);
    in_valid = 1'b1; in_size = sz; in_quad = q; half_en = he;
    in_dst_idx = di; in_src_idx = si; in_data = d;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back({ed, eu, ei});
    tag_q.push_back(tag);
    sent++;
  endtask

  // monitor and consumer back-pressure
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && out_valid && out_ready) begin
      logic [129:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++; got++;
      if ({out_data, out_undef, out_invalid} !== e) begin
        fails++;
        $display("FAIL %s: data=%h undef=%b inv=%b expected data=%h undef=%b inv=%b",
                 tg, out_data, out_undef, out_invalid, e[129:2], e[1], e[0]);
      end
    end
    out_ready <= (cyc >= 60 && cyc < 68) ? 1'b0 : ((cyc % 4) != 1);
  end

  task automatic finish_run;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #20000;
    checks++; fails++;
    $display("FAIL watchdog: got=%0d expected=%0d", got, sent);
    finish_run();
  end

  initial begin
    logic [127:0] rnd = 128'h1234_5678_9abc_def0_0fed_cba9_8765_4321;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    checks++;
    // R12: empty after reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R12 reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
    // R2 / R6: half lanes 1.5, -1.5, +0, -0
    send(2'b01, 1'b0, 1'b1, 5'd0, 5'd0, {64'hFFFF_0000_1111_2222, 64'h8000_0000_BE00_3E00}, "R2_R6_half");
    // R9 / R7: -0.5, 0.75, +inf, -inf
    send(2'b01, 1'b0, 1'b1, 5'd1, 5'd3, {64'h0, 64'hFC00_7C00_3A00_B800}, "R9_R7_half");
    // R8 / R11 / R10: sNaN, qNaN, -denormal, 1024.0
    send(2'b01, 1'b0, 1'b1, 5'd0, 5'd0, {64'h0, 64'h6400_8001_FE00_7C01}, "R8_R11_R10_half");
    // R1 / R2: single 2.5 and -2.5
    send(2'b10, 1'b0, 1'b1, 5'd0, 5'd0, {64'h0, 64'hC020_0000_4020_0000}, "R1_R2_single");
    // R9 carry: just below 1, just below -1, 1.0, -100.0 in quad
    send(2'b10, 1'b1, 1'b1, 5'd2, 5'd4, {64'hC2C8_0000_3F80_0000, 64'hBF80_0001_3F7F_FFFF}, "R9_R1_quad");
    // R10 / R8: 2^23+1 passthrough, sNaN single
    send(2'b10, 1'b1, 1'b1, 5'd0, 5'd6, {64'h7F80_0001_4B00_0001, 64'hFF80_0000_8000_0000}, "R10_R8_single");
    // R5: upper doubleword ignored in 64-bit mode, including an sNaN there
    send(2'b10, 1'b0, 1'b1, 5'd0, 5'd0, {64'h7F80_0001_7F80_0001, 64'h4040_0000_BFC0_0000}, "R5_upper");
    // R3: illegal sizes and half disabled
    send(2'b00, 1'b0, 1'b1, 5'd0, 5'd0, {64'h0, 64'h3F80_0000_7F80_0001}, "R3_size00");
    send(2'b11, 1'b1, 1'b1, 5'd0, 5'd0, {128{1'b1}}, "R3_size11");
    send(2'b01, 1'b0, 1'b0, 5'd0, 5'd0, {64'h0, 64'h3E00_3E00_3E00_7C01}, "R3_half_off");
    // R4: odd indices in quad, odd is fine in 64-bit mode
    send(2'b10, 1'b1, 1'b1, 5'd3, 5'd0, {64'h4020_0000_4020_0000, 64'h4020_0000_4020_0000}, "R4_dst_odd");
    send(2'b01, 1'b1, 1'b1, 5'd0, 5'd5, {64'h3E00_3E00_3E00_3E00, 64'h3E00_3E00_3E00_3E00}, "R4_src_odd");
    send(2'b01, 1'b1, 1'b1, 5'd8, 5'd10, {64'hBE00_B800_3A00_3E00, 64'hBE00_B800_3A00_3E00}, "R4_even_ok");
    // R1 / R12: pseudo-random patterns under back-pressure
    for (int n = 0; n < 24; n++) begin
      rnd = {rnd[126:0], rnd[127] ^ rnd[125] ^ rnd[100] ^ rnd[98]};
      rnd = rnd ^ (rnd << 13) ^ {64'h0, 64'h9E37_79B9_7F4A_7C15};
      send((n % 2) ? 2'b01 : 2'b10, (n % 3) != 0, 1'b1, 5'(2 * n), 5'(4 * n), rnd, "R1_R12_rand");
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (got < sent) @(negedge clk);
    finish_run();
  end
endmodule